// File: doc/BRIEF.md
# Carry-Partitioned Packed Adder

This block is a 32-bit integer adder whose carry chain can be cut at any bit position. A 32-bit split mask, held in a small register with its own write port, marks where each packed element begins. A set mask bit at position i stops the carry from reaching bit i. Between set bits the operands are summed as independent elements, and those elements can have any mix of widths. One example is a pair of 5-6-5 colour pixels, which is six fields summed side by side in one word.

Each operation selects either a plain add or a packed add. A plain add ignores the mask and always carries across the full word. Operands enter through a valid/ready stream. The result leaves one cycle later through a second valid/ready stream. The input side accepts a new operation whenever the output register is empty or is being drained in the same cycle. While the output is stalled, the result held there does not change. The mask port is a plain control interface and is never stalled.

Top module: `psimd_adder`

## Requirements
- R1: With `in_op`=0 (plain add), the result is (in_a + in_b) mod 2^32, whatever the split mask holds.
- R2: With `in_op`=1 (packed add), a set mask bit i (i ≥ 1) blocks the carry into bit i. Each element runs from a set bit, or from bit 0, up to the bit below the next set bit, or up to bit 31. Each element is summed modulo 2 to its own width, and the carry out of its top bit is dropped.
- R3: Mask bit 0 has no effect on any result. A read of `part_q` returns every written bit, bit 0 included.
- R4: A packed add with a mask of all zeros (bit 0 aside) gives exactly the plain sum.
- R5: A packed add with a mask of all ones gives in_a XOR in_b.
- R6: During and right after reset, `part_q` is zero and `out_valid` is low.
- R7: A mask write at a clock edge applies to operations accepted at later edges. An operation accepted at the same edge as the write uses the old mask.
- R8: An operation accepted at edge k (in_valid and in_ready high) shows its result with `out_valid` high after edge k.
- R9: `in_ready` = !out_valid || out_ready. While out_valid is high and out_ready is low, `out_valid` stays high and `out_sum` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block accepts the offered operation |
| in_op | input | 1 | 0 = plain add, 1 = packed add |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| part_we | input | 1 | Write strobe for the split mask |
| part_wdata | input | 32 | New split mask value |
| part_q | output | 32 | Current split mask |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_sum | output | 32 | Result |

## Verification
The bench drives the 5-6-5 pixel mask with operands that overflow only the lowest field. A leaking carry would ripple into the green field, and a missing cut would give the plain sum. A mask with only bit 0 set and a mask of all ones catch a design that decodes bit 0 as a cut or leaves carries running between single-bit elements. The bench also writes the mask in the same cycle as an operation, to catch a design that forwards the new value too early. Random stalls on the output check that a held result is neither overwritten nor dropped while ready is low.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  typedef enum logic {
    OP_PLAIN  = 1'b0,
    OP_PACKED = 1'b1
  } add_op_e;
endpackage

// File: rtl/psimd_split_reg.sv
module psimd_split_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end
endmodule

// File: rtl/psimd_kill_gen.sv
module psimd_kill_gen #(
  parameter int WIDTH = 32
) (
  input  psimd_pkg::add_op_e op,
  input  logic [WIDTH-1:0]   mask,
  output logic [WIDTH-1:0]   kill
);
  import psimd_pkg::*;
  // Bit 0 never receives a carry, so it is forced out of the kill vector.
  always_comb begin
    kill = (op == OP_PACKED) ? mask : '0;
    kill[0] = 1'b0;
  end
endmodule

// File: rtl/psimd_carry_chain.sv
module psimd_carry_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] kill,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH:0]   cin;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
    assign sum[i]  = prop[i] ^ cin[i];
    if (i < WIDTH - 1) begin : g_link
      assign cin[i+1] = (gen[i] | (prop[i] & cin[i])) & ~kill[i+1];
    end else begin : g_top
      assign cin[i+1] = gen[i] | (prop[i] & cin[i]);
    end
  end
endmodule

// File: rtl/psimd_out_stage.sv
module psimd_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [WIDTH-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [WIDTH-1:0] dn_data
);
  logic take;

  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dn_valid <= 1'b0;
    else if (up_ready) dn_valid <= up_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dn_data <= '0;
    else if (take) dn_data <= up_data;
  end
endmodule

// File: rtl/psimd_adder.sv
module psimd_adder #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic             part_we,
  input  logic [WIDTH-1:0] part_wdata,
  output logic [WIDTH-1:0] part_q,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_sum
);
  import psimd_pkg::*;

  add_op_e          op;
  logic [WIDTH-1:0] kill;
  logic [WIDTH-1:0] raw_sum;

  assign op = add_op_e'(in_op);

  psimd_split_reg #(.WIDTH(WIDTH)) u_split (
    .clk(clk), .rst_n(rst_n), .wr_en(part_we), .wr_data(part_wdata), .mask_q(part_q)
  );

  psimd_kill_gen #(.WIDTH(WIDTH)) u_kill (
    .op(op), .mask(part_q), .kill(kill)
  );

  psimd_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .a(in_a), .b(in_b), .kill(kill), .sum(raw_sum)
  );

  psimd_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(raw_sum),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_sum)
  );
endmodule

// File: rtl/psimd_adder_chk.sv
module psimd_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             part_we,
  input logic [WIDTH-1:0] part_wdata,
  input logic [WIDTH-1:0] part_q,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_sum
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_plain_full_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_op) |=> (out_valid && out_sum == $past(in_a + in_b)));

  a_r4_empty_mask_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op && part_q[WIDTH-1:1] == '0) |=> (out_sum == $past(in_a + in_b)));

  a_r5_full_mask_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op && (&part_q[WIDTH-1:1])) |=> (out_sum == $past(in_a ^ in_b)));

  a_r7_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    part_we |=> (part_q == $past(part_wdata)));

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

bind psimd_adder psimd_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .part_we(part_we),
  .part_wdata(part_wdata), .part_q(part_q), .out_valid(out_valid),
  .out_ready(out_ready), .out_sum(out_sum)
);

// File: tb/psimd_adder_test.sv
module psimd_adder_test;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_op = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        part_we = 1'b0;
  logic [31:0] part_wdata = '0;
  logic [31:0] part_q;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_sum;

  int          errors = 0;
  int          checks = 0;
  item_t       sb[$];
  logic [31:0] model_mask = '0;
  int          stall_mode = 0;
  int          popped = 0;
  int          pushed = 0;
  bit          held = 1'b0;
  logic [31:0] held_val = '0;

  always #4 clk = ~clk;

  psimd_adder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .part_we(part_we),
    .part_wdata(part_wdata), .part_q(part_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_sum(out_sum)
  );

  // Per-field reference, from R1/R2/R3: fields start at set mask bits (bit 0 always starts one).
  function automatic logic [31:0] ref_sum(bit op, logic [31:0] a, logic [31:0] b, logic [31:0] m);
    logic [31:0] bounds;
    logic [31:0] res;
    int lo;
    bounds = op ? m : 32'h0;
    bounds[0] = 1'b1;
    res = '0;
    lo = 0;
    for (int i = 1; i <= 32; i++) begin
      if (i == 32 || bounds[i]) begin
        logic [63:0] fm;
        logic [63:0] fs;
        fm = (64'd1 << (i - lo)) - 64'd1;
        fs = (((64'(a) >> lo) & fm) + ((64'(b) >> lo) & fm)) & fm;
        res = res | 32'(fs << lo);
        lo = i;
      end
    end
    return res;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: offers one operation, optionally writes the mask at the first edge.
  task automatic issue(bit op, logic [31:0] a, logic [31:0] b, string tag,
                       bit we = 1'b0, logic [31:0] wd = '0, bit lit = 1'b0,
                       logic [31:0] lit_exp = '0);
    bit first = 1'b1;
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    part_we = we; part_wdata = wd;
    while (!done) begin
      #2;
      if (in_ready) begin
        item_t it;
        it.exp = lit ? lit_exp : ref_sum(op, a, b, model_mask);
        it.tag = tag;
        sb.push_back(it);
        pushed++;
        done = 1'b1;
      end
      @(posedge clk);
      if (first && we) model_mask = wd;
      first = 1'b0;
      if (!done) begin
        @(negedge clk);
        part_we = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    part_we = 1'b0;
  endtask

  task automatic write_mask(logic [31:0] wd);
    @(negedge clk);
    part_we = 1'b1; part_wdata = wd;
    @(posedge clk);
    model_mask = wd;
    @(negedge clk);
    part_we = 1'b0;
  endtask

  task automatic drain;
    int n = 0;
    while (popped != pushed && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Ready pattern and monitor, both on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready = (stall_mode == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
      #1;
      if (held) begin
        check("R9 held value stable", out_sum, held_val);
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R8 unexpected output", out_sum, 32'hxxxxxxxx);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, out_sum, it.exp);
          popped++;
        end
      end else if (out_valid) begin
        held = 1'b1;
        held_val = out_sum;
      end
    end
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 mask at reset", part_q, 32'h0);
    check("R6 out_valid at reset", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check("R6 mask after reset", part_q, 32'h0);
    check("R6 out_valid after reset", {31'h0, out_valid}, 32'h0);

    // R8: an accepted op raises out_valid one edge later
    issue(1'b0, 32'd7, 32'd9, "R8 latency result");
    drain();

    // R1: plain add ignores a busy mask
    write_mask(32'hFFFF_FFFF);
    issue(1'b0, 32'hFFFF_FFFF, 32'h1, "R1 plain wraps", 1'b0, '0, 1'b1, 32'h0);
    issue(1'b0, 32'h0F0F_0F0F, 32'h0101_0101, "R1 plain carry",
          1'b0, '0, 1'b1, 32'h1010_1010);

    // R5: all-ones mask gives XOR
    issue(1'b1, 32'hDEAD_BEEF, 32'h1234_5678, "R5 xor", 1'b0, '0, 1'b1,
          32'hDEAD_BEEF ^ 32'h1234_5678);

    // R2: 5-6-5 pixel pair, cuts at 5,11,16,21,27
    write_mask(32'h0821_0820);
    issue(1'b1, 32'hFFFF_FFFF, 32'h1, "R2 565 low field wraps", 1'b0, '0, 1'b1,
          32'hFFFF_FFE0);
    issue(1'b1, 32'h0000_07E0, 32'h0000_0020, "R2 green field wraps", 1'b0, '0, 1'b1,
          32'h0000_0000);
    issue(1'b1, 32'h1234_5678, 32'h9ABC_DEF0, "R2 565 mixed");

    // R4 / R3: zero mask and bit-0-only mask match the plain sum
    write_mask(32'h0);
    issue(1'b1, 32'h7FFF_FFFF, 32'h1, "R4 empty mask sum", 1'b0, '0, 1'b1, 32'h8000_0000);
    write_mask(32'h1);
    @(negedge clk);
    #2;
    check("R3 bit0 readback", part_q, 32'h1);
    issue(1'b1, 32'hFFFF_FFFF, 32'h1, "R3 bit0 no effect", 1'b0, '0, 1'b1, 32'h0);

    // R7: write in the same cycle as an op, old mask applies
    issue(1'b1, 32'h0000_00FF, 32'h1, "R7 same edge uses old", 1'b1, 32'h0000_0100,
          1'b1, 32'h0000_0100);
    issue(1'b1, 32'h0000_00FF, 32'h1, "R7 next op uses new", 1'b0, '0, 1'b1, 32'h0);
    drain();

    // R9: random stalls with random masks and ops
    stall_mode = 1;
    for (int k = 0; k < 60; k++) begin
      if (k % 10 == 0) write_mask($urandom());
      issue(1'($urandom_range(0, 1)), $urandom(), $urandom(), "R9 stalled stream R2");
    end
    stall_mode = 0;
    drain();
    check("R9 all results delivered", 32'(popped), 32'(pushed));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule